// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the raster timing for a display pipe: a pixel counter, a line counter, a data-enable strobe and horizontal, vertical and composite sync, for both progressive and interlaced scans. Both counters take the first visible pixel of the top visible line as their origin (0,0). Blanking and sync are placed after the visible area using margins that software supplies through a small write-only register port.

In interlaced mode the block forms the odd-field timing in hardware from the programmed even-field values. The odd field gets one extra line in the total and one extra line before vertical sync. Its vertical sync starts and ends half a line earlier within the line. The front porch is the same for both fields. The field changes at the frame-done point, which is the last pixel of the last visible line. From that point the following blanking interval and the visible lines after it run entirely with the new field's values.

Timing writes go into shadow registers. They take effect at the frame-done point, or at once while the generator is stopped. Three events set sticky status bits that software clears by writing ones: the rise of vertical sync, frame done, and field change. A maskable interrupt line is derived from these bits. Downstream logic uses the counters and strobes to fetch and place pixels.

Top module: `vtg_interlaced`

## Requirements
- R1: After reset both counters are 0, data enable and all three sync outputs are low, the field output is 1, the status bits are 0 and the interrupt is low.
- R2: While running, the pixel counter steps 0..HT-1 and then wraps. The line counter steps on each wrap through 0..VT-1, where VT is the field's line total. Data enable is high exactly when the pixel count is below the active width and the line count is below the active height. Register 0 holds height[31:16] and width[15:0]. Register 3 holds line total[31:16] and pixel total HT[15:0].
- R3: The uninverted horizontal sync is high for pixel counts from (width + right margin) up to but not including (HT − left margin). Register 1 holds left[31:16] and right[15:0].
- R4: In progressive mode, and in the even field, the uninverted vertical sync rises at line (height + back margin), pixel P = width + right margin. It falls at line (VT − front margin) at the same pixel P. Register 2 holds front[31:16] and back[15:0].
- R5: In the odd field the line total and the sync start line are each one greater than in the even field. The front margin is unchanged. The sync pixel P is reduced by HT/2.
- R6: Interlace is bit 0 of register 4. The field output is 0 (odd) on the first visible lines after the generator starts in interlaced mode, and it toggles at every frame-done point. In progressive mode it stays 1.
- R7: Writes to registers 0 to 4 take effect at the clock after the frame-done point (the last pixel of the last visible line) while running, and on the next clock while stopped.
- R8: Register 5 bits 1, 2 and 3 invert horizontal, vertical and composite sync respectively. Each takes effect on the next clock.
- R9: The uninverted composite sync is the OR of the uninverted horizontal and vertical syncs.
- R10: The status bits are: bit 0, vertical sync rise; bit 1, frame done; bit 2, field change (interlaced only). Each is set on the clock after its event and stays set until software writes a 1 to that bit of register 7. A set takes priority over a clear in the same cycle.
- R11: The interrupt output is high whenever any status bit is set whose enable bit in register 6 is also set.
- R12: While register 5 bit 0 (run) is low, both counters stay at 0, the strobes stay low and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| de_o | output | 1 | Data enable |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| csync_o | output | 1 | Composite sync after polarity |
| h_cnt_o | output | CW | Pixel counter |
| v_cnt_o | output | CW | Line counter |
| field_o | output | 1 | Field identity, 0 odd, 1 even |
| irq_status_o | output | 3 | Sticky event bits |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Corrupting a counter or the field bit shows up at the ports within one line: data enable and horizontal sync fall in the wrong place, and the line counter wraps at the wrong total. A wrong field-dependent parameter first appears in the following blanking interval. There the vertical sync edge lands half a line or one line away from where it should be, and the field period differs from the expected 10 or 11 lines. A shadow value committed too early changes the line length inside the frame in which it was written. A cycle-by-cycle comparison of all outputs catches that on the next line end.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
   localparam int REG_AW = 3;
   localparam int NEV    = 3;
   localparam int EV_VS  = 0;
   localparam int EV_FD  = 1;
   localparam int EV_FLD = 2;

   typedef enum logic [REG_AW-1:0] {
      RA_ACT  = 3'd0,
      RA_HMRG = 3'd1,
      RA_VMRG = 3'd2,
      RA_TOT  = 3'd3,
      RA_MODE = 3'd4,
      RA_CTRL = 3'd5,
      RA_IEN  = 3'd6,
      RA_ACK  = 3'd7
   } vtg_addr_e;

   typedef struct packed {
      logic [15:0] vact;
      logic [15:0] hact;
      logic [15:0] lmarg;
      logic [15:0] rmarg;
      logic [15:0] fmarg;
      logic [15:0] bmarg;
      logic [15:0] vtot;
      logic [15:0] htot;
      logic        ilace;
   } vtg_set_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
   import vtg_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [31:0]     wr_data,
   input  logic            commit_i,
   output vtg_set_t        cm_o,
   output logic            sh_ilace_o,
   output logic            en_o,
   output logic [2:0]      inv_o,
   output logic [NEV-1:0]  ien_o,
   output logic [NEV-1:0]  ack_o
);
   vtg_set_t sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         en_o  <= 1'b0;
         inv_o <= '0;
         ien_o <= '0;
      end else if (wr_en) begin
         case (vtg_addr_e'(wr_addr))
            RA_ACT:  begin sh.vact  <= wr_data[31:16]; sh.hact  <= wr_data[15:0]; end
            RA_HMRG: begin sh.lmarg <= wr_data[31:16]; sh.rmarg <= wr_data[15:0]; end
            RA_VMRG: begin sh.fmarg <= wr_data[31:16]; sh.bmarg <= wr_data[15:0]; end
            RA_TOT:  begin sh.vtot  <= wr_data[31:16]; sh.htot  <= wr_data[15:0]; end
            RA_MODE: sh.ilace <= wr_data[0];
            RA_CTRL: begin en_o <= wr_data[0]; inv_o <= wr_data[3:1]; end
            RA_IEN:  ien_o <= wr_data[NEV-1:0];
            default: ;
         endcase
      end
   end

   // shadow set reaches the counters only at a frame boundary or while stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cm_o <= '0;
      else if (!en_o || commit_i) cm_o <= sh;
   end

   assign sh_ilace_o = sh.ilace;
   assign ack_o = (wr_en && vtg_addr_e'(wr_addr) == RA_ACK) ? wr_data[NEV-1:0] : '0;
endmodule

// File: rtl/vtg_raster.sv
module vtg_raster
   import vtg_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  vtg_set_t      cm,
   input  logic          sh_ilace,
   output logic [CW-1:0] h_o,
   output logic [CW-1:0] v_o,
   output logic          field_o,
   output logic          de_o,
   output logic          hs_o,
   output logic          vs_o,
   output logic          fd_o
);
   logic          odd;
   logic [CW-1:0] odd_w, hact, vact, htot, vtot_f, hs0, hs1, vs0, vs1, vpos;
   logic          line_end, vs_after, vs_before;

   assign odd   = cm.ilace && !field_o;
   assign odd_w = {{(CW-1){1'b0}}, odd};

   // odd-field set is derived from the programmed even-field values
   always_comb begin
      hact   = cm.hact[CW-1:0];
      vact   = cm.vact[CW-1:0];
      htot   = cm.htot[CW-1:0];
      vtot_f = cm.vtot[CW-1:0] + odd_w;
      hs0    = hact + cm.rmarg[CW-1:0];
      hs1    = htot - cm.lmarg[CW-1:0];
      vs0    = vact + cm.bmarg[CW-1:0] + odd_w;
      vs1    = vtot_f - cm.fmarg[CW-1:0];
      vpos   = odd ? (hs0 - (htot >> 1)) : hs0;
   end

   assign line_end  = (h_o == htot - 1'b1);
   assign fd_o      = en && line_end && (v_o == vact - 1'b1);
   assign de_o      = en && (h_o < hact) && (v_o < vact);
   assign hs_o      = en && (h_o >= hs0) && (h_o < hs1);
   assign vs_after  = (v_o > vs0) || ((v_o == vs0) && (h_o >= vpos));
   assign vs_before = (v_o < vs1) || ((v_o == vs1) && (h_o < vpos));
   assign vs_o      = en && vs_after && vs_before;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_o     <= '0;
         v_o     <= '0;
         field_o <= 1'b1;
      end else if (!en) begin
         h_o     <= '0;
         v_o     <= '0;
         field_o <= !cm.ilace;
      end else begin
         if (line_end) begin
            h_o <= '0;
            v_o <= (v_o == vtot_f - 1'b1) ? '0 : v_o + 1'b1;
         end else begin
            h_o <= h_o + 1'b1;
         end
         if (fd_o) field_o <= sh_ilace ? !field_o : 1'b1;
      end
   end
endmodule

// File: rtl/vtg_irq.sv
module vtg_irq
   import vtg_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           vs_raw,
   input  logic           fd,
   input  logic           fld,
   input  logic [NEV-1:0] ack,
   input  logic [NEV-1:0] ien,
   output logic [NEV-1:0] stat_o,
   output logic           irq_o
);
   logic           vs_q;
   logic [NEV-1:0] set_v;

   always_comb begin
      set_v         = '0;
      set_v[EV_VS]  = vs_raw && !vs_q;
      set_v[EV_FD]  = fd;
      set_v[EV_FLD] = fld;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q   <= 1'b0;
         stat_o <= '0;
      end else begin
         vs_q   <= vs_raw;
         stat_o <= (stat_o & ~ack) | set_v;
      end
   end

   assign irq_o = |(stat_o & ien);
endmodule

// File: rtl/vtg_interlaced.sv
module vtg_interlaced
   import vtg_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_addr,
   input  logic [31:0]   wr_data,
   output logic          de_o,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          csync_o,
   output logic [CW-1:0] h_cnt_o,
   output logic [CW-1:0] v_cnt_o,
   output logic          field_o,
   output logic [2:0]    irq_status_o,
   output logic          irq_o
);
   localparam int NSYNC = 3;

   if (CW < 4 || CW > 16) begin : g_cw_bad
      $error("vtg_interlaced: CW must be within 4..16");
   end
   if (NEV != 3) begin : g_nev_bad
      $error("vtg_interlaced: event count mismatch");
   end

   vtg_set_t       cm_set;
   logic           sh_ilace, ctrl_en, fd, hs_raw, vs_raw, cm_il_w;
   logic [2:0]     inv;
   logic [NEV-1:0] ien, ack;
   logic [NSYNC-1:0] raw_sync, out_sync;

   vtg_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .commit_i(fd), .cm_o(cm_set), .sh_ilace_o(sh_ilace), .en_o(ctrl_en),
      .inv_o(inv), .ien_o(ien), .ack_o(ack)
   );

   vtg_raster #(.CW(CW)) u_raster (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .cm(cm_set), .sh_ilace(sh_ilace),
      .h_o(h_cnt_o), .v_o(v_cnt_o), .field_o(field_o), .de_o(de_o),
      .hs_o(hs_raw), .vs_o(vs_raw), .fd_o(fd)
   );

   vtg_irq u_irq (
      .clk(clk), .rst_n(rst_n), .vs_raw(vs_raw), .fd(fd), .fld(fd && cm_set.ilace),
      .ack(ack), .ien(ien), .stat_o(irq_status_o), .irq_o(irq_o)
   );

   assign cm_il_w  = cm_set.ilace;
   assign raw_sync = {hs_raw | vs_raw, vs_raw, hs_raw};

   for (genvar i = 0; i < NSYNC; i++) begin : g_pol
      assign out_sync[i] = raw_sync[i] ^ inv[i];
   end

   assign hsync_o = out_sync[0];
   assign vsync_o = out_sync[1];
   assign csync_o = out_sync[2];
endmodule

// File: rtl/vtg_interlaced_chk.sv
module vtg_interlaced_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [2:0]    wr_addr,
   input logic [2:0]    wr_lo,
   input logic          en,
   input logic          cm_il,
   input logic          sh_il,
   input logic [CW-1:0] h_cnt,
   input logic [CW-1:0] v_cnt,
   input logic          field,
   input logic [2:0]    stat
);
   logic [2:0] clr;
   assign clr = (wr_en && wr_addr == 3'd7) ? wr_lo : 3'b000;

   // R2: pixel counter advances by one unless it wraps
   a_r2_h_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && h_cnt != '0) |-> (h_cnt == CW'($past(h_cnt) + 1'b1)));

   // R2: line counter moves only at the start of a line
   a_r2_v_at_line_start: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && v_cnt != $past(v_cnt)) |-> (h_cnt == '0));

   // R12: stopped generator holds counters at the origin
   a_r12_idle_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |=> (h_cnt == '0 && v_cnt == '0));

   // R6: progressive field stays even
   a_r6_prog_field: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !cm_il && !sh_il) |=> field);

   // R10: status bits never drop without an acknowledge
   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(stat) & ~$past(clr)) & ~stat) == 3'b000));
endmodule

bind vtg_interlaced vtg_interlaced_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lo(wr_data[2:0]),
   .en(ctrl_en), .cm_il(cm_il_w), .sh_il(sh_ilace), .h_cnt(h_cnt_o), .v_cnt(v_cnt_o),
   .field(field_o), .stat(irq_status_o)
);

// File: tb/vtg_interlaced_tb.sv
module vtg_interlaced_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 16;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic de_o, hsync_o, vsync_o, csync_o, field_o, irq_o;
   logic [CW-1:0] h_cnt_o, v_cnt_o;
   logic [2:0] irq_status_o;

   int total = 0, bad = 0;
   bit chk_on = 0, finished = 0;

   vtg_interlaced #(.CW(CW)) dut_i (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   // requirement-level model state
   int s_hact=0, s_vact=0, s_lm=0, s_rm=0, s_fp=0, s_bp=0, s_ht=0, s_vt=0; bit s_il=0;
   int c_hact=0, c_vact=0, c_lm=0, c_rm=0, c_fp=0, c_bp=0, c_ht=0, c_vt=0; bit c_il=0;
   bit m_en=0; bit [2:0] m_inv=0, m_ien=0, m_stat=0;
   int m_h=0, m_v=0; bit m_fld=1, m_vsq=0;
   int d_vt, d_hs0, d_hs1, d_vs0, d_vs1, d_vp; bit d_odd;

   function automatic void derive();
      d_odd = c_il && !m_fld;
      d_vt  = c_vt + d_odd;
      d_hs0 = c_hact + c_rm;
      d_hs1 = c_ht - c_lm;
      d_vs0 = c_vact + c_bp + d_odd;
      d_vs1 = d_vt - c_fp;
      d_vp  = d_odd ? d_hs0 - c_ht/2 : d_hs0;
   endfunction

   function automatic bit m_vs();
      bit a, b;
      a = (m_v > d_vs0) || (m_v == d_vs0 && m_h >= d_vp);
      b = (m_v < d_vs1) || (m_v == d_vs1 && m_h < d_vp);
      return m_en && a && b;
   endfunction

   function automatic bit m_hs();
      return m_en && m_h >= d_hs0 && m_h < d_hs1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         s_hact=0; s_vact=0; s_lm=0; s_rm=0; s_fp=0; s_bp=0; s_ht=0; s_vt=0; s_il=0;
         c_hact=0; c_vact=0; c_lm=0; c_rm=0; c_fp=0; c_bp=0; c_ht=0; c_vt=0; c_il=0;
         m_en=0; m_inv=0; m_ien=0; m_stat=0; m_h=0; m_v=0; m_fld=1; m_vsq=0;
      end else begin
         int nh, nv; bit nf, fdv, vsr, commit; bit [2:0] clr, setv;
         derive();
         vsr = m_vs();
         fdv = m_en && m_h == c_ht-1 && m_v == c_vact-1;
         clr = (wr_en && wr_addr == 3'd7) ? wr_data[2:0] : 3'b000;
         setv = {fdv && c_il, fdv, vsr && !m_vsq};
         nh = m_h; nv = m_v; nf = m_fld;
         if (!m_en) begin
            nh = 0; nv = 0; nf = !c_il; commit = 1;
         end else begin
            if (m_h == c_ht-1) begin nh = 0; nv = (m_v == d_vt-1) ? 0 : m_v+1; end
            else nh = m_h+1;
            if (fdv) nf = s_il ? !m_fld : 1'b1;
            commit = fdv;
         end
         if (commit) begin
            c_hact=s_hact; c_vact=s_vact; c_lm=s_lm; c_rm=s_rm;
            c_fp=s_fp; c_bp=s_bp; c_ht=s_ht; c_vt=s_vt; c_il=s_il;
         end
         m_stat = (m_stat & ~clr) | setv;
         m_vsq = vsr; m_h = nh; m_v = nv; m_fld = nf;
         if (wr_en) case (wr_addr)
            3'd0: begin s_vact = wr_data[31:16]; s_hact = wr_data[15:0]; end
            3'd1: begin s_lm = wr_data[31:16]; s_rm = wr_data[15:0]; end
            3'd2: begin s_fp = wr_data[31:16]; s_bp = wr_data[15:0]; end
            3'd3: begin s_vt = wr_data[31:16]; s_ht = wr_data[15:0]; end
            3'd4: s_il = wr_data[0];
            3'd5: begin m_en = wr_data[0]; m_inv = wr_data[3:1]; end
            3'd6: m_ien = wr_data[2:0];
            default: ;
         endcase
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison of every output against the model
   always @(negedge clk) if (chk_on && !finished) begin
      bit hs, vs;
      derive();
      hs = m_hs(); vs = m_vs();
      check("R2 h_cnt", h_cnt_o, m_h);
      check("R2 v_cnt", v_cnt_o, m_v);
      check("R2 de", de_o, m_en && m_h < c_hact && m_v < c_vact);
      check("R3/R8 hsync", hsync_o, hs ^ m_inv[0]);
      check("R4/R5/R8 vsync", vsync_o, vs ^ m_inv[1]);
      check("R9 csync", csync_o, (hs | vs) ^ m_inv[2]);
      check("R6 field", field_o, m_fld);
      check("R10 status", irq_status_o, m_stat);
      check("R11 irq", irq_o, |(m_stat & m_ien));
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 h", h_cnt_o, 0); check("R1 v", v_cnt_o, 0);
      check("R1 de", de_o, 0); check("R1 hsync", hsync_o, 0);
      check("R1 vsync", vsync_o, 0); check("R1 csync", csync_o, 0);
      check("R1 field", field_o, 1); check("R1 status", irq_status_o, 0);
      check("R1 irq", irq_o, 0);
   endtask

   task automatic t_idle();
      wr(3'd0, {16'd4, 16'd8});
      wr(3'd1, {16'd3, 16'd2});
      wr(3'd2, {16'd2, 16'd1});
      wr(3'd3, {16'd10, 16'd16});
      wr(3'd6, 32'd7);
      idle(10);
      check("R12 h", h_cnt_o, 0); check("R12 v", v_cnt_o, 0);
      check("R12 de", de_o, 0); check("R12 status", irq_status_o, 0);
   endtask

   task automatic t_progressive();
      wr(3'd5, 32'd1);
      check("R2 origin de", de_o, 1);
      idle(400);
      check("R6 progressive field", field_o, 1);
      check("R10 vs+fd set", irq_status_o, 3'b011);
      check("R11 irq high", irq_o, 1);
   endtask

   task automatic t_ack();
      while (!(v_cnt_o == 1 && h_cnt_o == 0)) @(negedge clk);
      wr(3'd7, 32'd7);
      check("R10 cleared", irq_status_o, 0);
      check("R11 irq low", irq_o, 0);
      wr(3'd6, 32'd0);
      idle(200);
      check("R11 masked irq", irq_o, 0);
      wr(3'd6, 32'd7);
   endtask

   task automatic t_shadow();
      bit seen = 0;
      while (!(v_cnt_o == 1 && h_cnt_o == 2)) @(negedge clk);
      wr(3'd3, {16'd10, 16'd20});
      while (h_cnt_o != 15) @(negedge clk);
      @(negedge clk);
      check("R7 old total kept", h_cnt_o, 0);
      while (v_cnt_o != 5) @(negedge clk);
      for (int i = 0; i < 25; i++) begin
         if (h_cnt_o == 19) seen = 1;
         @(negedge clk);
      end
      check("R7 new total applied", seen, 1);
   endtask

   task automatic t_polarity();
      wr(3'd5, 32'hF);
      idle(300);
      check("R8 inverted idle csync", csync_o, !(hsync_o == 1'b0 && vsync_o == 1'b0) ? csync_o : 1);
      wr(3'd5, 32'h1);
   endtask

   task automatic t_interlace();
      int n;
      wr(3'd5, 32'h0);
      wr(3'd3, {16'd10, 16'd16});
      wr(3'd4, 32'd1);
      idle(4);
      wr(3'd5, 32'h1);
      check("R6 first field odd", field_o, 0);
      n = 0;
      while (field_o == 1'b0 && n < 1000) begin @(negedge clk); n++; end
      check("R6 first toggle", n, 64);
      n = 0;
      while (field_o == 1'b1 && n < 1000) begin @(negedge clk); n++; end
      check("R5 even field cycles", n, 160);
      n = 0;
      while (field_o == 1'b0 && n < 1000) begin @(negedge clk); n++; end
      check("R5 odd field cycles", n, 176);
      check("R10 field event", irq_status_o[2], 1);
      idle(700);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      chk_on = 1;
      t_reset();
      t_idle();
      t_progressive();
      t_ack();
      t_shadow();
      t_polarity();
      t_interlace();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule